// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an asynchronous 64K x 16 static RAM that has separate strobes for its low and high bytes. The host issues one request at a time. A request carries an address, 16 bits of write data, a two-bit lane mask and a read/write flag. The host holds `host_valid` until the controller pulses `host_ready`.

The controller turns each request into the memory's control sequence. It asserts chip select and the lane strobes, then output enable for a read. For a write it sets up the data drive, pulses the write line, releases the write line, and only then releases the data drive. Wait counts come from the clock period and the memory's timing figures. The read wait is the ceiling of access time over clock period, plus one cycle to register the data. The write pulse is the ceiling of the pulse width over the clock period. A change of direction between two requests costs one idle turnaround cycle on the bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and while idle, `mem_cs_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are high, `mem_dq_oe` is low and `host_ready` is low.
- R2: For a write, mask bit 0 maps to `mem_lb_n` (data bits 7:0) and mask bit 1 maps to `mem_ub_n` (data bits 15:8). Only the enabled bytes of the memory word change.
- R3: A read returns the stored byte in each enabled lane and zero in each disabled lane.
- R4: A request with mask 2'b00 keeps both lane strobes high and never pulses `mem_we_n`. The memory is left unchanged and the read data is zero.
- R5: `mem_we_n` is low only while `mem_cs_n` is low, at least one lane strobe is low, `mem_dq_oe` is high and `mem_oe_n` is high.
- R6: The write line falls only after a cycle in which chip select, address and strobes were already applied. The address and strobes hold steady while `mem_we_n` is low, and `mem_addr` equals the request address whenever chip select is low.
- R7: `mem_dq_oe` high and `mem_oe_n` low never occur in the same cycle.
- R8: The write pulse lasts exactly ceil(WPW_PS/CLK_PS) cycles. `mem_we_n` rises while the data drive is still enabled, and the drive is released one cycle later.
- R9: Without turnaround, a read completes ceil(ACC_PS/CLK_PS)+1 cycles after acceptance. A write completes ceil(WPW_PS/CLK_PS)+2 cycles after acceptance.
- R10: When a request's direction differs from the previous request's, one extra cycle is inserted. In that cycle `mem_cs_n` and `mem_oe_n` are high and `mem_dq_oe` is low.
- R11: `host_ready` is high for exactly one cycle per request. Read data is valid on `host_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Request present; held until ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with ready |
| mem_addr | output | AW | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write line, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-byte strobe, active low |
| mem_ub_n | output | 1 | High-byte strobe, active low |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Sampled data bus |

## Verification
Directed cases cover full-word, low-only, high-only and empty-mask writes, each followed by reads under every mask. These show whether the lane strobes and the read masking are wired to the right byte. Read-after-read and write-after-write sequences are run against alternating read and write sequences. The comparison separates the base latency from the inserted turnaround cycle. A long random mix of addresses, data, masks and directions is checked against a shadow copy of the memory. It catches stray writes through a disabled lane, and a write that commits before or after its data is stable.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW     = 16,
  parameter int LANE_W = 8,
  parameter int CLK_PS = 8000,
  parameter int ACC_PS = 10000,
  parameter int WPW_PS = 9000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_valid,
  input  logic                host_write,
  input  logic [AW-1:0]       host_addr,
  input  logic [2*LANE_W-1:0] host_wdata,
  input  logic [1:0]          host_be,
  output logic                host_ready,
  output logic [2*LANE_W-1:0] host_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_cs_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [2*LANE_W-1:0] mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_in
);
  localparam int DW     = 2 * LANE_W;
  localparam int RD_CYC = (ACC_PS + CLK_PS - 1) / CLK_PS + 1;
  localparam int WR_CYC = (WPW_PS + CLK_PS - 1) / CLK_PS;
  localparam int MAXC   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW     = $clog2(MAXC) + 1;

  typedef enum logic [2:0] {IDLE, TURN, RD_WAIT, WR_SETUP, WR_PULSE, WR_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rdata_q;
  logic [1:0]    be_q;
  logic          wr_q, last_wr, last_vld;
  logic          active, drive, rd_last;

  assign active  = (st == RD_WAIT) || drive;
  assign drive   = (st == WR_SETUP) || (st == WR_PULSE) || (st == WR_HOLD);
  assign rd_last = (st == RD_WAIT) && (cnt == CW'(RD_CYC - 1));

  assign mem_addr   = addr_q;
  assign mem_dq_out = data_q;
  assign mem_dq_oe  = drive;
  assign mem_cs_n   = !active;
  assign mem_lb_n   = !(active && be_q[0]);
  assign mem_ub_n   = !(active && be_q[1]);
  assign mem_oe_n   = (st != RD_WAIT);
  assign mem_we_n   = !((st == WR_PULSE) && (|be_q));
  assign host_ready = rd_last || (st == WR_HOLD);
  assign host_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      rdata_q  <= '0;
      be_q     <= '0;
      wr_q     <= 1'b0;
      last_wr  <= 1'b0;
      last_vld <= 1'b0;
    end else begin
      case (st)
        IDLE: if (host_valid) begin
          addr_q   <= host_addr;
          data_q   <= host_wdata;
          be_q     <= host_be;
          wr_q     <= host_write;
          last_wr  <= host_write;
          last_vld <= 1'b1;
          cnt      <= '0;
          if (last_vld && (last_wr != host_write)) st <= TURN;
          else st <= host_write ? WR_SETUP : RD_WAIT;
        end
        TURN: st <= wr_q ? WR_SETUP : RD_WAIT;
        RD_WAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(RD_CYC - 2))
            rdata_q <= mem_dq_in & {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};
          if (rd_last) st <= IDLE;
        end
        WR_SETUP: begin
          cnt <= '0;
          st  <= WR_PULSE;
        end
        WR_PULSE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(WR_CYC - 1)) st <= WR_HOLD;
        end
        WR_HOLD: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW    = 16,
  parameter int PULSE = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic          mem_dq_oe,
  input logic          host_ready
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!mem_we_n) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  assert_we_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && !(mem_lb_n && mem_ub_n) && mem_dq_oe && mem_oe_n));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_we_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

  assert_drive_after_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_cnt == 8'(PULSE)));

  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW), .PULSE(WR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
  .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe), .host_ready(host_ready)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
  localparam int AW = 16, CLK_PS = 8000, ACC_PS = 10000, WPW_PS = 9000;
  localparam int EXP_RD = (ACC_PS + CLK_PS - 1) / CLK_PS + 1;
  localparam int EXP_WR = (WPW_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_write = 0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0] host_be = '0;
  logic host_ready;
  logic [15:0] host_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

  int vectors = 0, errors = 0;
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  bit have_last = 0, last_wr = 0;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.AW(AW), .CLK_PS(CLK_PS), .ACC_PS(ACC_PS), .WPW_PS(WPW_PS)) dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .host_ready(host_ready), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ?
    {mem_ub_n ? 8'hA5 : mem[mem_addr[7:0]][15:8], mem_lb_n ? 8'h5A : mem[mem_addr[7:0]][7:0]} :
    16'hC33C;

  always @(posedge mem_we_n) begin
    if (mem_cs_n === 1'b0) begin
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
  end

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input logic [1:0] be);
    return shadow[a[7:0]] & lane_mask(be);
  endfunction

  function automatic int exp_latency(input bit wr, input bit turn);
    return (turn ? 1 : 0) + (wr ? EXP_WR + 2 : EXP_RD);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    bit turn;
    int n, lowc, exp_lat;
    bit addr_ok, strobe_ok, turn_ok, contention;
    logic [15:0] expd;
    turn = have_last && (last_wr != wr);
    exp_lat = exp_latency(wr, turn);
    expd = exp_read(a, be);
    @(negedge clk);
    host_valid = 1; host_write = wr; host_addr = a; host_wdata = d; host_be = be;
    n = 0; lowc = 0; addr_ok = 1; strobe_ok = 1; turn_ok = 1; contention = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (!mem_cs_n && mem_addr !== a) addr_ok = 0;
      if (mem_dq_oe && !mem_oe_n) contention = 1;
      if (!mem_we_n) begin
        lowc++;
        if (mem_lb_n !== !be[0] || mem_ub_n !== !be[1] || !mem_dq_oe) strobe_ok = 0;
      end
      if (!mem_cs_n && (mem_lb_n !== !be[0] || mem_ub_n !== !be[1])) strobe_ok = 0;
      if (turn && n == 1 && !(mem_cs_n && mem_oe_n && !mem_dq_oe)) turn_ok = 0;
      if (host_ready || n > 40) break;
    end
    host_valid = 0;
    check(n == exp_lat, turn ? "R10 latency with turnaround" : "R9 latency", n, exp_lat);
    check(addr_ok, "R6 address while selected", mem_addr, a);
    check(strobe_ok, "R2 lane strobes", {mem_ub_n, mem_lb_n}, {!be[1], !be[0]});
    check(!contention, "R7 bus contention", 1, 0);
    if (turn) check(turn_ok, "R10 turnaround cycle idle", 0, 1);
    if (wr) begin
      check(lowc == ((be != 0) ? EXP_WR : 0), (be != 0) ? "R8 pulse length" : "R4 no pulse", lowc,
            (be != 0) ? EXP_WR : 0);
      shadow[a[7:0]] = (shadow[a[7:0]] & ~lane_mask(be)) | (d & lane_mask(be));
    end else begin
      check(host_rdata == expd, (be == 0) ? "R4 empty-mask read" : "R3 read data", host_rdata, expd);
    end
    @(negedge clk);
    check(!host_ready, "R11 single ready", host_ready, 0);
    if (wr) check(mem[a[7:0]] == shadow[a[7:0]], "R2 memory contents", mem[a[7:0]], shadow[a[7:0]]);
    have_last = 1; last_wr = wr;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101 + 16'h1234);
      shadow[i] = mem[i];
    end
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !host_ready,
          "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, host_ready}, 7'b1111100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_ready, "R1 idle after reset",
          {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_ready}, 5'b11100);

    do_op(0, 16'h0010, 16'h0, 2'b11);
    do_op(0, 16'h0011, 16'h0, 2'b11);
    do_op(1, 16'h0010, 16'hBEEF, 2'b11);
    do_op(1, 16'h0020, 16'h1177, 2'b01);
    do_op(1, 16'h0021, 16'h8822, 2'b10);
    do_op(1, 16'h0022, 16'hFFFF, 2'b00);
    do_op(0, 16'h0010, 16'h0, 2'b11);
    do_op(0, 16'h0020, 16'h0, 2'b11);
    do_op(0, 16'h0021, 16'h0, 2'b11);
    do_op(0, 16'h0022, 16'h0, 2'b11);
    do_op(0, 16'h0010, 16'h0, 2'b01);
    do_op(0, 16'h0010, 16'h0, 2'b10);
    do_op(0, 16'h0010, 16'h0, 2'b00);
    do_op(1, 16'hFFFF, 16'h6A6A, 2'b11);
    do_op(0, 16'hFFFF, 16'h0, 2'b11);

    for (int k = 0; k < 400; k++)
      do_op(1'($urandom), 16'($urandom), 16'($urandom), 2'($urandom));

    for (int i = 0; i < 256; i++)
      if (mem[i] !== shadow[i]) check(0, "R2 final memory image", mem[i], shadow[i]);
    vectors++;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule